// File: doc/BRIEF.md
# Gated-Zone Video Statistics Collector

This block watches a Y/Cr/Cb pixel stream and measures the picture inside a rectangular window that the host programs. It tracks the current column and row from the pixel valid, line and field sync inputs, and decides for every pixel whether it falls inside the window. For the pixels inside, it keeps running sums of luma, red chroma and blue chroma, and the largest luma value seen. Host software uses these figures to steer exposure and white balance. The block makes no control decisions of its own.

The window corners are given as coarse column and row values in steps of four pixels. The working totals restart at every field sync. At the same edge, the totals of the field just finished are copied into output registers that stay steady for the host to read during the whole next field. A one-cycle ready pulse marks each copy.

Top module: `zone_stats`

## Requirements
- R1: While rst_ni is low, all four result outputs read zero and stats_ready_o is low.
- R2: Bits [7:0] of zone_start_i and zone_end_i hold the column corner and bits [15:8] hold the row corner, both in units of 4 pixels. A pixel at (col,row) is inside the zone when start_col*4 <= col <= end_col*4+3 and start_row*4 <= row <= end_row*4+3.
- R3: The column count advances by one only on cycles that carry a valid pixel with no sync, and returns to 0 on hsync_i or vsync_i. The row count returns to 0 on vsync_i and advances by one on each hsync_i. The first pixel after a sync is at column 0.
- R4: luma_sum_o reports the sum of the luma values of all in-zone pixels of the last completed field.
- R5: luma_peak_o reports the largest luma value among the in-zone pixels of the last completed field, or 0 if there were none.
- R6: cr_sum_o and cb_sum_o report the sums of the in-zone chroma samples, each taken as an unsigned 8-bit value.
- R7: A sum that would exceed its width stays at all ones and does not wrap.
- R8: In a cycle with vsync_i high, the totals of the finished field appear on the outputs after that clock edge. stats_ready_o is high for the one cycle that follows, and the totals restart from zero. The outputs do not change at any other edge.
- R9: Pixels outside the zone, cycles with pix_valid_i low, and pixels that arrive in the same cycle as hsync_i or vsync_i add nothing to any result.
- R10: If the zone end is below the zone start on either axis, the zone holds no pixel and all four results read zero for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Pixel present this cycle |
| hsync_i | input | 1 | Line sync pulse, one cycle |
| vsync_i | input | 1 | Field sync pulse, one cycle |
| y_i | input | 8 | Luma sample |
| cr_i | input | 8 | Red chroma sample, offset binary |
| cb_i | input | 8 | Blue chroma sample, offset binary |
| zone_start_i | input | 16 | Zone start corner: row [15:8], column [7:0] |
| zone_end_i | input | 16 | Zone end corner: row [15:8], column [7:0] |
| luma_sum_o | output | SUM_W | Luma sum of last field |
| luma_peak_o | output | 8 | Peak luma of last field |
| cr_sum_o | output | SUM_W | Red chroma sum of last field |
| cb_sum_o | output | SUM_W | Blue chroma sum of last field |
| stats_ready_o | output | 1 | One-cycle pulse after each field latch |

## Verification
The bench targets the zone edges: a window that starts at column and row zero, and windows offset by whole 4-pixel steps. A design that got the `*4+3` inclusive end wrong, or counted idle cycles as columns, would drift its totals away from the model. A field shaped so that the 16-bit bench sums overflow shows whether a design wraps instead of holding all ones. Fields with the end corner placed before the start on one axis at a time must yield zeros, which catches a design that compares the corners loosely. Pixels placed on line sync cycles, and idle gaps inside lines, check that only genuine in-zone pixels count. The per-cycle comparison also catches a ready pulse that is late or too long, and results that change outside the latch edge.

// File: rtl/zone_stats_pkg.sv
package zone_stats_pkg;
  localparam int unsigned GRAN_SHIFT = 2;  // zone corners in 4-pixel steps
  localparam int unsigned NUM_SUMS   = 3;  // luma, cr, cb
  localparam int unsigned AX_COL     = 0;
  localparam int unsigned AX_ROW     = 1;
endpackage

// File: rtl/zone_axis_cmp.sv
module zone_axis_cmp #(
  parameter int unsigned POS_W  = 10,
  parameter int unsigned ZONE_W = 8
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [ZONE_W-1:0] lo_i,
  input  logic [ZONE_W-1:0] hi_i,
  output logic              hit_o
);
  import zone_stats_pkg::*;
  localparam int unsigned BND_W = ZONE_W + GRAN_SHIFT;

  logic [BND_W-1:0] lo_pix, hi_pix;
  logic [POS_W-1:0] lo_ext, hi_ext;

  always_comb begin
    lo_pix = {lo_i, {GRAN_SHIFT{1'b0}}};
    hi_pix = {hi_i, {GRAN_SHIFT{1'b1}}};
    lo_ext = POS_W'(lo_pix);
    hi_ext = POS_W'(hi_pix);
    hit_o  = (pos_i >= lo_ext) && (pos_i <= hi_ext);
  end
endmodule

// File: rtl/zone_pos_tracker.sv
module zone_pos_tracker #(
  parameter int unsigned POS_W  = 10,
  parameter int unsigned ZONE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [2*ZONE_W-1:0] zone_start_i,
  input  logic [2*ZONE_W-1:0] zone_end_i,
  output logic              take_o
);
  import zone_stats_pkg::*;

  logic [POS_W-1:0] col_q, row_q;
  logic [POS_W-1:0] pos [2];
  logic [1:0]       hit;
  logic             pix_live;

  assign pix_live = pix_valid_i && !hsync_i && !vsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (vsync_i) begin
      col_q <= '0;
      row_q <= '0;
    end else if (hsync_i) begin
      col_q <= '0;
      if (row_q != '1) row_q <= row_q + 1'b1;
    end else if (pix_valid_i && col_q != '1) begin
      col_q <= col_q + 1'b1;
    end
  end

  assign pos[AX_COL] = col_q;
  assign pos[AX_ROW] = row_q;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    zone_axis_cmp #(.POS_W(POS_W), .ZONE_W(ZONE_W)) u_cmp (
      .pos_i (pos[a]),
      .lo_i  (zone_start_i[a*ZONE_W +: ZONE_W]),
      .hi_i  (zone_end_i[a*ZONE_W +: ZONE_W]),
      .hit_o (hit[a])
    );
  end

  assign take_o = pix_live && (&hit);
endmodule

// File: rtl/zone_sat_accum.sv
module zone_sat_accum #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned SUM_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [IN_W-1:0]  val_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W:0]   sum_wide;

  assign sum_wide = {1'b0, sum_q} + (SUM_W+1)'(val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_wide[SUM_W] ? '1 : sum_wide[SUM_W-1:0];
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/zone_peak.sv
module zone_peak #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         upd_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] peak_o
);
  logic [W-1:0] peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        peak_q <= '0;
    else if (clr_i)                     peak_q <= '0;
    else if (upd_i && val_i > peak_q)   peak_q <= val_i;
  end

  assign peak_o = peak_q;
endmodule

// File: rtl/zone_stats.sv
module zone_stats #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ZONE_W = 8,
  parameter int unsigned POS_W  = 10,
  parameter int unsigned SUM_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pix_valid_i,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic [PIX_W-1:0]    y_i,
  input  logic [PIX_W-1:0]    cr_i,
  input  logic [PIX_W-1:0]    cb_i,
  input  logic [2*ZONE_W-1:0] zone_start_i,
  input  logic [2*ZONE_W-1:0] zone_end_i,
  output logic [SUM_W-1:0]    luma_sum_o,
  output logic [PIX_W-1:0]    luma_peak_o,
  output logic [SUM_W-1:0]    cr_sum_o,
  output logic [SUM_W-1:0]    cb_sum_o,
  output logic                stats_ready_o
);
  import zone_stats_pkg::*;

  logic                take;
  logic [PIX_W-1:0]    samp [NUM_SUMS];
  logic [SUM_W-1:0]    acc  [NUM_SUMS];
  logic [SUM_W-1:0]    shd_q [NUM_SUMS];
  logic [PIX_W-1:0]    peak_live, peak_shd_q;
  logic                ready_q;

  zone_pos_tracker #(.POS_W(POS_W), .ZONE_W(ZONE_W)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pix_valid_i  (pix_valid_i),
    .hsync_i      (hsync_i),
    .vsync_i      (vsync_i),
    .zone_start_i (zone_start_i),
    .zone_end_i   (zone_end_i),
    .take_o       (take)
  );

  assign samp[0] = y_i;
  assign samp[1] = cr_i;
  assign samp[2] = cb_i;

  for (genvar i = 0; i < NUM_SUMS; i++) begin : g_sum
    zone_sat_accum #(.IN_W(PIX_W), .SUM_W(SUM_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (vsync_i),
      .add_i  (take),
      .val_i  (samp[i]),
      .sum_o  (acc[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      shd_q[i] <= '0;
      else if (vsync_i) shd_q[i] <= acc[i];
    end
  end

  zone_peak #(.W(PIX_W)) u_peak (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vsync_i),
    .upd_i  (take),
    .val_i  (y_i),
    .peak_o (peak_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_shd_q <= '0;
      ready_q    <= 1'b0;
    end else begin
      ready_q <= vsync_i;
      if (vsync_i) peak_shd_q <= peak_live;
    end
  end

  assign luma_sum_o    = shd_q[0];
  assign cr_sum_o      = shd_q[1];
  assign cb_sum_o      = shd_q[2];
  assign luma_peak_o   = peak_shd_q;
  assign stats_ready_o = ready_q;
endmodule

// File: rtl/zone_stats_chk.sv
module zone_stats_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned SUM_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vsync_i,
  input logic [SUM_W-1:0] luma_sum_o,
  input logic [PIX_W-1:0] luma_peak_o,
  input logic [SUM_W-1:0] cr_sum_o,
  input logic [SUM_W-1:0] cb_sum_o,
  input logic             stats_ready_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (luma_sum_o == '0 && luma_peak_o == '0 &&
                                cr_sum_o == '0 && cb_sum_o == '0 && !stats_ready_o);
    end
  end

  a_r8_ready_after_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> stats_ready_o);

  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> !stats_ready_o);

  a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stats_ready_o |-> ($stable(luma_sum_o) && $stable(luma_peak_o) &&
                        $stable(cr_sum_o) && $stable(cb_sum_o)));

  a_r5_peak_within_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    luma_sum_o >= SUM_W'(luma_peak_o));

  a_r5_zero_sum_zero_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (luma_sum_o == '0) |-> (luma_peak_o == '0));
endmodule

bind zone_stats zone_stats_chk #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vsync_i       (vsync_i),
  .luma_sum_o    (luma_sum_o),
  .luma_peak_o   (luma_peak_o),
  .cr_sum_o      (cr_sum_o),
  .cb_sum_o      (cb_sum_o),
  .stats_ready_o (stats_ready_o)
);

// File: tb/tb_zone_stats.sv
`timescale 1ns/1ps
module tb_zone_stats;
  localparam int SW = 16;  // narrow sums so saturation is reachable
  localparam longint SMAX = (64'd1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pv = 0, hs = 0, vs = 0;
  logic [7:0] y = 0, cr = 0, cb = 0;
  logic [15:0] zs = 0, ze = 0;
  logic [SW-1:0] lsum, crs, cbs;
  logic [7:0] lpk;
  logic rdy;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  zone_stats #(.SUM_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pv), .hsync_i(hs), .vsync_i(vs),
    .y_i(y), .cr_i(cr), .cb_i(cb), .zone_start_i(zs), .zone_end_i(ze),
    .luma_sum_o(lsum), .luma_peak_o(lpk), .cr_sum_o(crs), .cb_sum_o(cbs),
    .stats_ready_o(rdy)
  );

  // behavioural reference
  int m_col, m_row;
  longint a_y, a_cr, a_cb, s_y, s_cr, s_cb;
  int a_pk, s_pk;
  bit m_rdy;

  function automatic longint sat_add(longint a, int v);
    longint t = a + v;
    return (t > SMAX) ? SMAX : t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 0; m_row = 0; a_y = 0; a_cr = 0; a_cb = 0; a_pk = 0;
      s_y = 0; s_cr = 0; s_cb = 0; s_pk = 0; m_rdy = 0;
    end else if (vs) begin
      s_y = a_y; s_cr = a_cr; s_cb = a_cb; s_pk = a_pk;
      a_y = 0; a_cr = 0; a_cb = 0; a_pk = 0;
      m_col = 0; m_row = 0; m_rdy = 1;
    end else begin
      m_rdy = 0;
      if (hs) begin
        m_col = 0; m_row++;
      end else if (pv) begin
        if (m_col >= zs[7:0]*4 && m_col <= ze[7:0]*4+3 &&
            m_row >= zs[15:8]*4 && m_row <= ze[15:8]*4+3) begin
          a_y = sat_add(a_y, y); a_cr = sat_add(a_cr, cr); a_cb = sat_add(a_cb, cb);
          if (y > a_pk) a_pk = y;
        end
        m_col++;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison (R4 R5 R6 R7 R8 R9 via model)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 luma_sum", lsum, s_y);
      chk("R5 luma_peak", lpk, s_pk);
      chk("R6 cr_sum", crs, s_cr);
      chk("R6 cb_sum", cbs, s_cb);
      chk("R8 stats_ready", rdy, m_rdy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic cyc(bit v, bit h, bit s, int yy, int rr, int bb);
    @(posedge clk); #1;
    pv = v; hs = h; vs = s; y = 8'(yy); cr = 8'(rr); cb = 8'(bb);
  endtask

  task automatic run_field(int rows, int cols, int seed, int gap, bit flat);
    cyc(0, 0, 1, 0, 0, 0);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        if (gap != 0 && ((c + r) % gap) == 0) cyc(0, 0, 0, 250, 250, 250); // R3 idle gap
        if (flat) cyc(1, 0, 0, 255, 255, 255);
        else cyc(1, 0, 0, c*29 + r*53 + seed, c*11 + seed*3 + r, 255 - c*5 - r*17 + seed);
      end
      cyc(1, 1, 0, 255, 255, 255);  // R9 pixel on hsync is dropped
    end
  endtask

  task automatic latch();
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  initial begin
    #1;
    #10;
    @(negedge clk);
    chk("R1 reset luma_sum", lsum, 0);
    chk("R1 reset peak", lpk, 0);
    chk("R1 reset cr_sum", crs, 0);
    chk("R1 reset cb_sum", cbs, 0);
    chk("R1 reset ready", rdy, 0);
    rst_n = 1'b1;

    // R2 R3 offset window rows 4..7, cols 4..11
    zs = {8'd1, 8'd1}; ze = {8'd1, 8'd2};
    run_field(12, 16, 3, 0, 0);
    // R2 origin window with idle gaps
    zs = 16'h0000; ze = 16'h0000;
    run_field(8, 8, 77, 3, 0);
    // R10 empty on column axis
    zs = {8'd0, 8'd3}; ze = {8'd2, 8'd1};
    run_field(10, 16, 5, 0, 0);
    latch();
    chk("R10 col-empty luma_sum", lsum, 0);
    chk("R10 col-empty peak", lpk, 0);
    chk("R10 col-empty cr_sum", crs, 0);
    // R7 saturation: 768 pixels of 255
    zs = 16'h0000; ze = {8'd2, 8'd15};
    run_field(12, 64, 0, 0, 1);
    latch();
    chk("R7 luma_sum saturated", lsum, SMAX);
    chk("R7 cr_sum saturated", crs, SMAX);
    chk("R7 cb_sum saturated", cbs, SMAX);
    chk("R5 peak at full scale", lpk, 255);
    // R10 empty on row axis
    zs = {8'd2, 8'd0}; ze = {8'd1, 8'd3};
    run_field(12, 16, 9, 0, 0);
    latch();
    chk("R10 row-empty luma_sum", lsum, 0);
    chk("R10 row-empty cb_sum", cbs, 0);
    // wide window with gaps, R4 R5 R6
    zs = {8'd0, 8'd1}; ze = {8'd2, 8'd3};
    run_field(10, 20, 41, 4, 0);
    latch();
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule